// File: doc/BRIEF.md
# 8b/10b Code-Group Decoder with Idle Removal

This block is on the receive side of a serial link that uses 8b/10b line coding. Each clock it accepts one 10-bit code group. It gives back the 8-bit value, a flag that marks control characters, and two error flags: one for groups that no valid encoder could produce, and one for groups that are legal but carry the wrong running disparity. It keeps the running disparity of the stream and shows it on an output.

The work is split over three register stages. A slot is decoded only when the enable input is high in that slot. When the idle-drop input is high, the comma idle character (K28.5, in either disparity form) is taken out of the output stream: its slot shows valid low, but the idle still moves the running disparity forward. Word alignment, rate matching and deserialisation are done outside this block.

Bit order of the code group: `code_in[9:4]` carries the six-bit sub-block a,b,c,d,e,i with a in bit 9, and `code_in[3:0]` carries f,g,h,j with f in bit 3. The decoded byte holds EDCBA in `byte_out[4:0]` and HGF in `byte_out[7:5]`, so Dx.y gives `{y[2:0], x[4:0]}`.

Top module: `dec8b10b_top`

## Requirements
- R1: An input sampled at rising edge N shows up on every output right after rising edge N+2, which makes three register stages. The output slot matches the input slot exactly.
- R2: While `rst_n` is low, every register is cleared asynchronously with no clock edge needed. All outputs then read 0, and running disparity 0 means negative.
- R3: A slot sampled with `dec_en` low gives `valid_out` 0, `byte_out` 0, `ctrl_out` 0 and both error flags 0. `rd_out` does not change in that slot.
- R4: A valid data group Dx.y, sent with the current running disparity, gives `valid_out` 1, `byte_out` = {y,x}, `ctrl_out` 0 and both error flags 0. Every one of the 256 data values decodes this way.
- R5: Each of the twelve control groups (K28.0 to K28.7, K23.7, K27.7, K29.7, K30.7) decodes to its byte value, for example 8'hBC for K28.5, with `ctrl_out` 1.
- R6: A 10-bit pattern that is not a legal code group in either disparity gives `valid_out` 1, `code_err` 1, `disp_err` 0, `byte_out` 0 and `ctrl_out` 0. `rd_out` keeps its previous value.
- R7: A legal group that is legal only for the opposite running disparity gives `disp_err` 1 together with its decoded byte and control flag. The running disparity resyncs to the value that follows that group when it is encoded from the opposite disparity.
- R8: After each legal group, `rd_out` (1 = positive) equals the disparity at the end of that group.
- R9: With `idle_drop` high when it is sampled, a K28.5 (10'h0FA or 10'h305) gives `valid_out` 0 and zero on byte, control and error outputs, but `rd_out` still advances. With `idle_drop` low, K28.5 passes as in R5, and other groups are never dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_en | input | 1 | Decode the group in this slot |
| idle_drop | input | 1 | Remove K28.5 idles from the output stream |
| code_in | input | 10 | Received code group, a in bit 9 |
| byte_out | output | 8 | Decoded value {HGF, EDCBA} |
| ctrl_out | output | 1 | Decoded group is a control character |
| code_err | output | 1 | Group is not in the code table |
| disp_err | output | 1 | Group is legal only for the opposite disparity |
| rd_out | output | 1 | Running disparity after this slot, 1 = positive |
| valid_out | output | 1 | Output slot holds a delivered character |

## Verification
The bound checker watches four things on every clock. It checks that a valid output always traces back to an enabled input exactly three samples earlier. It checks that an idle slot or a code error leaves the running disparity alone. It checks that both error flags are never high together, and that a raw K28.5 seen while idle-drop was high never comes out as valid. The bench scenarios are needed for the rest: the exact decoded value of every data and control group, resync after a disparity error, the disparity sequence across whole streams, and the asynchronous clear taking effect between clock edges.

// File: rtl/dec8b10b_pkg.sv
package dec8b10b_pkg;

  localparam int CODE_W = 10;
  localparam int BYTE_W = 8;
  localparam int SIX_W  = 6;
  localparam int FOUR_W = 4;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              rd_end;
  } enc_res_t;

  typedef struct packed {
    logic              hit;
    logic              ctl;
    logic [BYTE_W-1:0] val;
  } dec_res_t;

  typedef struct packed {
    logic              en;
    logic              idle_hit;
    logic              ok;
    logic              ctl;
    logic [BYTE_W-1:0] val;
    logic              m_neg;
    logic              m_pos;
    logic              end_neg;
    logic              end_pos;
  } look_t;

  // Six-bit sub-block for value x when the disparity is negative (abcdei, a in MSB)
  function automatic logic [SIX_W-1:0] six_neg(input logic [4:0] x);
    logic [SIX_W-1:0] r;
    case (x)
      5'd0:  r = 6'b100111;  5'd1:  r = 6'b011101;
      5'd2:  r = 6'b101101;  5'd3:  r = 6'b110001;
      5'd4:  r = 6'b110101;  5'd5:  r = 6'b101001;
      5'd6:  r = 6'b011001;  5'd7:  r = 6'b111000;
      5'd8:  r = 6'b111001;  5'd9:  r = 6'b100101;
      5'd10: r = 6'b010101;  5'd11: r = 6'b110100;
      5'd12: r = 6'b001101;  5'd13: r = 6'b101100;
      5'd14: r = 6'b011100;  5'd15: r = 6'b010111;
      5'd16: r = 6'b011011;  5'd17: r = 6'b100011;
      5'd18: r = 6'b010011;  5'd19: r = 6'b110010;
      5'd20: r = 6'b001011;  5'd21: r = 6'b101010;
      5'd22: r = 6'b011010;  5'd23: r = 6'b111010;
      5'd24: r = 6'b110011;  5'd25: r = 6'b100110;
      5'd26: r = 6'b010110;  5'd27: r = 6'b110110;
      5'd28: r = 6'b001110;  5'd29: r = 6'b101110;
      5'd30: r = 6'b011110;  default: r = 6'b101011;
    endcase
    return r;
  endfunction

  // Four-bit sub-block of a data group at negative disparity (fghj)
  function automatic logic [FOUR_W-1:0] four_data(input logic [2:0] y);
    logic [FOUR_W-1:0] r;
    case (y)
      3'd0: r = 4'b1011;  3'd1: r = 4'b1001;
      3'd2: r = 4'b0101;  3'd3: r = 4'b1100;
      3'd4: r = 4'b1101;  3'd5: r = 4'b1010;
      3'd6: r = 4'b0110;  default: r = 4'b1110;
    endcase
    return r;
  endfunction

  // Four-bit sub-block of a control group at negative disparity
  function automatic logic [FOUR_W-1:0] four_ctl(input logic [2:0] y);
    logic [FOUR_W-1:0] r;
    case (y)
      3'd0: r = 4'b1011;  3'd1: r = 4'b0110;
      3'd2: r = 4'b1010;  3'd3: r = 4'b1100;
      3'd4: r = 4'b1101;  3'd5: r = 4'b0101;
      3'd6: r = 4'b1001;  default: r = 4'b0111;
    endcase
    return r;
  endfunction

  function automatic logic alt7_neg(input logic [4:0] x);
    return (x == 5'd17) || (x == 5'd18) || (x == 5'd20);
  endfunction

  function automatic logic alt7_pos(input logic [4:0] x);
    return (x == 5'd11) || (x == 5'd13) || (x == 5'd14);
  endfunction

  function automatic logic k7_row(input logic [4:0] x);
    return (x == 5'd23) || (x == 5'd27) || (x == 5'd29) || (x == 5'd30);
  endfunction

  // Encode one value starting from running disparity rd (1 = positive)
  function automatic enc_res_t encode_group(input logic [BYTE_W-1:0] b,
                                            input logic ctl, input logic rd);
    enc_res_t          res;
    logic [4:0]        x;
    logic [2:0]        y;
    logic [SIX_W-1:0]  base6;
    logic [SIX_W-1:0]  c6;
    logic [FOUR_W-1:0] c4;
    logic              k28;
    logic              mid;
    x     = b[4:0];
    y     = b[7:5];
    k28   = ctl && (x == 5'd28);
    base6 = k28 ? 6'b001111 : six_neg(x);
    if (rd && (($countones(base6) != 3) || (!ctl && x == 5'd7)))
      c6 = ~base6;
    else
      c6 = base6;
    if ($countones(c6) == 4)      mid = 1'b1;
    else if ($countones(c6) == 2) mid = 1'b0;
    else                          mid = rd;
    if (ctl) begin
      c4 = mid ? ~four_ctl(y) : four_ctl(y);
    end else if (y == 3'd7) begin
      if (!mid)      c4 = alt7_neg(x) ? 4'b0111 : 4'b1110;
      else           c4 = alt7_pos(x) ? 4'b1000 : 4'b0001;
    end else if (mid && (y == 3'd0 || y == 3'd3 || y == 3'd4)) begin
      c4 = ~four_data(y);
    end else begin
      c4 = four_data(y);
    end
    res.code = {c6, c4};
    if ($countones(c4) == 3)      res.rd_end = 1'b1;
    else if ($countones(c4) == 1) res.rd_end = 1'b0;
    else                          res.rd_end = mid;
    return res;
  endfunction

  // Map a group back to a candidate value; legality is confirmed by re-encoding
  function automatic dec_res_t decode_group(input logic [CODE_W-1:0] code);
    dec_res_t          res;
    logic [SIX_W-1:0]  c6;
    logic [FOUR_W-1:0] c4;
    logic [FOUR_W-1:0] f;
    logic [SIX_W-1:0]  base;
    logic [SIX_W-1:0]  alt;
    logic [4:0]        x;
    logic [2:0]        y;
    logic              hit6;
    logic              hit4;
    logic              k28;
    c6   = code[CODE_W-1:FOUR_W];
    c4   = code[FOUR_W-1:0];
    x    = '0;
    y    = '0;
    hit6 = 1'b0;
    hit4 = 1'b0;
    k28  = (c6 == 6'b001111) || (c6 == 6'b110000);
    if (k28) begin
      hit6 = 1'b1;
      x    = 5'd28;
    end else begin
      for (int v = 0; v < 32; v++) begin
        base = six_neg(5'(v));
        alt  = (($countones(base) != 3) || v == 7) ? ~base : base;
        if (c6 == base || c6 == alt) begin
          hit6 = 1'b1;
          x    = 5'(v);
        end
      end
    end
    res.ctl = 1'b0;
    if (k28) begin
      f       = (c6 == 6'b001111) ? ~c4 : c4;
      res.ctl = 1'b1;
      for (int w = 0; w < 8; w++) begin
        if (four_ctl(3'(w)) == f) begin
          hit4 = 1'b1;
          y    = 3'(w);
        end
      end
    end else begin
      hit4 = 1'b1;
      case (c4)
        4'b1011, 4'b0100:                   y = 3'd0;
        4'b1001:                            y = 3'd1;
        4'b0101:                            y = 3'd2;
        4'b1100, 4'b0011:                   y = 3'd3;
        4'b1101, 4'b0010:                   y = 3'd4;
        4'b1010:                            y = 3'd5;
        4'b0110:                            y = 3'd6;
        4'b1110, 4'b0001, 4'b0111, 4'b1000: y = 3'd7;
        default:                            hit4 = 1'b0;
      endcase
      res.ctl = (c4 == 4'b0111 || c4 == 4'b1000) && k7_row(x);
    end
    res.hit = hit6 && hit4;
    res.val = {y, x};
    return res;
  endfunction

endpackage

// File: rtl/dec8b10b_in_stage.sv
module dec8b10b_in_stage
  import dec8b10b_pkg::*;
#(
  parameter int W = CODE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         idle_i,
  input  logic [W-1:0] code_i,
  output logic         en_q,
  output logic         idle_q,
  output logic [W-1:0] code_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      idle_q <= 1'b0;
      code_q <= '0;
    end else begin
      en_q   <= en_i;
      idle_q <= idle_i;
      code_q <= code_i;
    end
  end
endmodule

// File: rtl/dec8b10b_lookup.sv
module dec8b10b_lookup
  import dec8b10b_pkg::*;
#(
  parameter logic [BYTE_W-1:0] IDLE_VAL = 8'hBC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              idle_i,
  input  logic [CODE_W-1:0] code_i,
  output look_t             look_q
);
  dec_res_t dec;
  enc_res_t from_neg;
  enc_res_t from_pos;
  look_t    look_d;

  always_comb begin
    dec             = decode_group(code_i);
    from_neg        = encode_group(dec.val, dec.ctl, 1'b0);
    from_pos        = encode_group(dec.val, dec.ctl, 1'b1);
    look_d.en       = en_i;
    look_d.m_neg    = dec.hit && (from_neg.code == code_i);
    look_d.m_pos    = dec.hit && (from_pos.code == code_i);
    look_d.ok       = look_d.m_neg || look_d.m_pos;
    look_d.ctl      = dec.ctl;
    look_d.val      = dec.val;
    look_d.end_neg  = from_neg.rd_end;
    look_d.end_pos  = from_pos.rd_end;
    look_d.idle_hit = idle_i && look_d.ok && dec.ctl && (dec.val == IDLE_VAL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) look_q <= '0;
    else        look_q <= look_d;
  end
endmodule

// File: rtl/dec8b10b_rd_track.sv
module dec8b10b_rd_track
  import dec8b10b_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  look_t             look_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              ctrl_o,
  output logic              code_err_o,
  output logic              disp_err_o,
  output logic              rd_o,
  output logic              valid_o
);
  logic agree;
  logic rd_next;

  always_comb begin
    agree = rd_o ? look_i.m_pos : look_i.m_neg;
    if (!look_i.en || !look_i.ok) rd_next = rd_o;
    else if (agree)               rd_next = rd_o ? look_i.end_pos : look_i.end_neg;
    else                          rd_next = rd_o ? look_i.end_neg : look_i.end_pos;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_o     <= '0;
      ctrl_o     <= 1'b0;
      code_err_o <= 1'b0;
      disp_err_o <= 1'b0;
      rd_o       <= 1'b0;
      valid_o    <= 1'b0;
    end else begin
      rd_o <= rd_next;
      if (!look_i.en || look_i.idle_hit) begin
        byte_o     <= '0;
        ctrl_o     <= 1'b0;
        code_err_o <= 1'b0;
        disp_err_o <= 1'b0;
        valid_o    <= 1'b0;
      end else begin
        valid_o    <= 1'b1;
        byte_o     <= look_i.ok ? look_i.val : '0;
        ctrl_o     <= look_i.ok && look_i.ctl;
        code_err_o <= !look_i.ok;
        disp_err_o <= look_i.ok && !agree;
      end
    end
  end
endmodule

// File: rtl/dec8b10b_top.sv
module dec8b10b_top
  import dec8b10b_pkg::*;
#(
  parameter logic [BYTE_W-1:0] IDLE_VAL = 8'hBC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_en,
  input  logic              idle_drop,
  input  logic [CODE_W-1:0] code_in,
  output logic [BYTE_W-1:0] byte_out,
  output logic              ctrl_out,
  output logic              code_err,
  output logic              disp_err,
  output logic              rd_out,
  output logic              valid_out
);
  logic              s1_en;
  logic              s1_idle;
  logic [CODE_W-1:0] s1_code;
  look_t             s2_look;

  dec8b10b_in_stage #(.W(CODE_W)) u_in (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (dec_en),
    .idle_i (idle_drop),
    .code_i (code_in),
    .en_q   (s1_en),
    .idle_q (s1_idle),
    .code_q (s1_code)
  );

  dec8b10b_lookup #(.IDLE_VAL(IDLE_VAL)) u_look (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (s1_en),
    .idle_i (s1_idle),
    .code_i (s1_code),
    .look_q (s2_look)
  );

  dec8b10b_rd_track u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .look_i     (s2_look),
    .byte_o     (byte_out),
    .ctrl_o     (ctrl_out),
    .code_err_o (code_err),
    .disp_err_o (disp_err),
    .rd_o       (rd_out),
    .valid_o    (valid_out)
  );
endmodule

// File: rtl/dec8b10b_checker.sv
module dec8b10b_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       dec_en,
  input logic       idle_drop,
  input logic [9:0] code_in,
  input logic [7:0] byte_out,
  input logic       ctrl_out,
  input logic       code_err,
  input logic       disp_err,
  input logic       rd_out,
  input logic       valid_out
);
  logic [2:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  since_rst <= '0;
    else if (since_rst != 3'd7)  since_rst <= since_rst + 3'd1;
  end

  // R1, R3: a delivered slot comes from an input enabled three samples back
  a_r1_valid_from_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd3 && valid_out) |-> $past(dec_en, 3));

  // R3: running disparity holds across a disabled slot
  a_r3_rd_holds_idle_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd3 && !$past(dec_en, 3)) |-> $stable(rd_out));

  // R6: an illegal group leaves the running disparity where it was
  a_r6_code_err_keeps_rd: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd1 && code_err) |-> $stable(rd_out));

  // R6, R7: one error kind per slot
  a_r6_errors_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(code_err && disp_err));

  // R4: flags only appear on a delivered slot
  a_r4_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_out || code_err || disp_err || byte_out != 8'h00) |-> valid_out);

  // R9: comma idle is never delivered while removal was requested
  a_r9_idle_removed: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd3 && $past(dec_en, 3) && $past(idle_drop, 3) &&
     ($past(code_in, 3) == 10'h0FA || $past(code_in, 3) == 10'h305)) |-> !valid_out);
endmodule

bind dec8b10b_top dec8b10b_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dec_en    (dec_en),
  .idle_drop (idle_drop),
  .code_in   (code_in),
  .byte_out  (byte_out),
  .ctrl_out  (ctrl_out),
  .code_err  (code_err),
  .disp_err  (disp_err),
  .rd_out    (rd_out),
  .valid_out (valid_out)
);

// File: tb/dec8b10b_top_tb_top.sv
`timescale 1ns/1ps
module dec8b10b_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dec_en = 1'b0;
  logic       idle_drop = 1'b0;
  logic [9:0] code_in = '0;
  logic [7:0] byte_out;
  logic       ctrl_out, code_err, disp_err, rd_out, valid_out;

  int checks = 0;
  int errors = 0;
  logic mrd = 1'b0;
  bit   mon_on = 1'b0;

  typedef struct {
    logic       v;
    logic [7:0] b;
    logic       c;
    logic       ec;
    logic       ed;
    logic       rd;
    string      req;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  dec8b10b_top dut_i (
    .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .idle_drop(idle_drop),
    .code_in(code_in), .byte_out(byte_out), .ctrl_out(ctrl_out),
    .code_err(code_err), .disp_err(disp_err), .rd_out(rd_out), .valid_out(valid_out)
  );

  function automatic logic [5:0] tb_six(input logic [4:0] x);
    logic [5:0] t [32] = '{6'b100111, 6'b011101, 6'b101101, 6'b110001,
                           6'b110101, 6'b101001, 6'b011001, 6'b111000,
                           6'b111001, 6'b100101, 6'b010101, 6'b110100,
                           6'b001101, 6'b101100, 6'b011100, 6'b010111,
                           6'b011011, 6'b100011, 6'b010011, 6'b110010,
                           6'b001011, 6'b101010, 6'b011010, 6'b111010,
                           6'b110011, 6'b100110, 6'b010110, 6'b110110,
                           6'b001110, 6'b101110, 6'b011110, 6'b101011};
    return t[x];
  endfunction

  function automatic logic [3:0] tb_k4(input logic [2:0] y);
    logic [3:0] t [8] = '{4'b1011, 4'b0110, 4'b1010, 4'b1100,
                          4'b1101, 4'b0101, 4'b1001, 4'b0111};
    return t[y];
  endfunction

  // returns {rd after group, code group}
  function automatic logic [10:0] tb_enc(input logic [7:0] b, input logic k, input logic rd);
    logic [4:0] x; logic [2:0] y; logic [5:0] s; logic [3:0] f; logic r1, r2; int n;
    x = b[4:0]; y = b[7:5];
    s = (k && x == 5'd28) ? 6'b001111 : tb_six(x);
    if (rd && ((!k && x == 5'd7) || $countones(s) != 3)) s = ~s;
    n = $countones(s);
    r1 = (n == 4) ? 1'b1 : (n == 2) ? 1'b0 : rd;
    if (k) f = r1 ? ~tb_k4(y) : tb_k4(y);
    else begin
      case (y)
        3'd0: f = r1 ? 4'b0100 : 4'b1011;
        3'd1: f = 4'b1001;
        3'd2: f = 4'b0101;
        3'd3: f = r1 ? 4'b0011 : 4'b1100;
        3'd4: f = r1 ? 4'b0010 : 4'b1101;
        3'd5: f = 4'b1010;
        3'd6: f = 4'b0110;
        default:
          if (r1) f = (x == 11 || x == 13 || x == 14) ? 4'b1000 : 4'b0001;
          else    f = (x == 17 || x == 18 || x == 20) ? 4'b0111 : 4'b1110;
      endcase
    end
    n = $countones(f);
    r2 = (n == 3) ? 1'b1 : (n == 1) ? 1'b0 : r1;
    return {r2, s, f};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic e, input logic idl, input logic [9:0] cw, input exp_t ex);
    @(negedge clk);
    dec_en = e; idle_drop = idl; code_in = cw;
    q.push_back(ex);
  endtask

  task automatic send_word(input logic [7:0] b, input logic k, input logic idl,
                           input bit wrong, input string req);
    logic [10:0] good, used;
    exp_t ex;
    bit deleted, derr;
    good = tb_enc(b, k, mrd);
    used = wrong ? tb_enc(b, k, ~mrd) : good;
    derr = wrong && (used[9:0] != good[9:0]);
    mrd = derr ? used[10] : good[10];
    deleted = idl && k && b == 8'hBC;
    ex.v = !deleted; ex.b = deleted ? 8'h00 : b; ex.c = !deleted && k;
    ex.ec = 1'b0; ex.ed = !deleted && derr; ex.rd = mrd; ex.req = req;
    drive(1'b1, idl, used[9:0], ex);
  endtask

  task automatic send_bad(input logic [9:0] cw);
    exp_t ex;
    ex.v = 1'b1; ex.b = 8'h00; ex.c = 1'b0; ex.ec = 1'b1; ex.ed = 1'b0;
    ex.rd = mrd; ex.req = "R6";
    drive(1'b1, 1'b0, cw, ex);
  endtask

  task automatic send_gap(input logic [9:0] cw, input string req);
    exp_t ex;
    ex.v = 1'b0; ex.b = 8'h00; ex.c = 1'b0; ex.ec = 1'b0; ex.ed = 1'b0;
    ex.rd = mrd; ex.req = req;
    drive(1'b0, 1'b1, cw, ex);
  endtask

  // scoreboard monitor: the item driven three negedges ago is due now
  always @(negedge clk) begin
    #1;
    if (mon_on) begin
      while (q.size() > 3) begin
        exp_t e;
        bit ok;
        e = q.pop_front();
        ok = (valid_out === e.v) && (byte_out === e.b) && (ctrl_out === e.c) &&
             (code_err === e.ec) && (disp_err === e.ed) && (rd_out === e.rd);
        check(ok, e.req, "v/byte/ctrl/ec/ed/rd",
              {19'd0, valid_out, byte_out, ctrl_out, code_err, disp_err, rd_out},
              {19'd0, e.v, e.b, e.c, e.ec, e.ed, e.rd});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] kcodes [12] = '{8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC,
                                8'hDC, 8'hFC, 8'hF7, 8'hFB, 8'hFD, 8'hFE};
    // R2: outputs cleared while reset is held, even with an enabled input
    dec_en = 1'b1; code_in = 10'h0FA;
    repeat (4) @(negedge clk);
    check(valid_out === 1'b0 && rd_out === 1'b0 && byte_out === 8'h00 &&
          code_err === 1'b0 && disp_err === 1'b0 && ctrl_out === 1'b0,
          "R2", "reset state", {valid_out, rd_out, byte_out}, 32'd0);
    dec_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;

    // R1: isolated word between disabled slots lands in its own slot
    send_gap(10'h000, "R1");
    send_word(8'h4A, 1'b0, 1'b0, 1'b0, "R1");
    send_gap(10'h0FA, "R1");
    send_gap(10'h0FA, "R1");
    send_gap(10'h0FA, "R1");

    // R4, R8, R3: every data value, with disabled slots mixed in
    for (int i = 0; i < 256; i++) begin
      send_word(8'(i), 1'b0, 1'b0, 1'b0, "R4");
      if (i % 16 == 7) send_gap(10'h3FF, "R3");
    end
    send_word(8'h00, 1'b0, 1'b0, 1'b0, "R8");
    send_word(8'h03, 1'b0, 1'b0, 1'b0, "R8");

    // R5: control characters from both disparities, no removal
    for (int r = 0; r < 2; r++)
      for (int j = 0; j < 12; j++) send_word(kcodes[j], 1'b1, 1'b0, 1'b0, "R5");

    // R9: idle removal, both forms, rd still advances; data passes
    for (int j = 0; j < 4; j++) begin
      send_word(8'hBC, 1'b1, 1'b1, 1'b0, "R9");
      send_word(8'h95, 1'b0, 1'b1, 1'b0, "R9");
      send_word(8'h1C, 1'b1, 1'b1, 1'b0, "R9");
    end
    send_word(8'hBC, 1'b1, 1'b0, 1'b0, "R9");

    // R7: groups sent with the wrong disparity
    send_word(8'h00, 1'b0, 1'b0, 1'b1, "R7");
    send_word(8'hBC, 1'b1, 1'b0, 1'b1, "R7");
    send_word(8'h27, 1'b0, 1'b0, 1'b1, "R7");
    send_word(8'h15, 1'b0, 1'b0, 1'b1, "R7");
    send_word(8'hF7, 1'b1, 1'b0, 1'b1, "R7");
    send_word(8'h11, 1'b0, 1'b0, 0, "R7");
    send_word(8'hBC, 1'b1, 1'b1, 1'b1, "R7");

    // R6: illegal patterns leave rd alone
    send_bad(10'h000);
    send_bad(10'h3FF);
    send_bad(10'b1111111010);
    send_bad(10'b1001110000);
    send_bad(10'b1000111110);
    send_bad(10'b1010010111);
    send_word(8'h3C, 1'b1, 1'b0, 1'b0, "R8");
    send_bad(10'b0011110000);

    while (mrd == 1'b0) send_word(8'hBC, 1'b1, 1'b0, 1'b0, "R8");
    for (int j = 0; j < 4; j++) send_gap(10'h000, "R3");
    @(negedge clk); #1;
    mon_on = 1'b0;
    check(rd_out === 1'b1, "R8", "rd before async clear", {31'd0, rd_out}, 32'd1);
    // R2: asynchronous clear between edges
    #0.2 rst_n = 1'b0;
    #0.3;
    check(rd_out === 1'b0 && valid_out === 1'b0, "R2", "async clear",
          {30'd0, rd_out, valid_out}, 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule